// File: doc/BRIEF.md
# Electronic Shutter Timing Controller

This block converts a 10-bit shutter code into a storage-start strobe that is placed within the frame timing of an image sensor. The line counter and the frame-start strobe come from the sync generator. Two exposure ranges share the code space. In the line range the exposure lasts between 2 and 524 lines of a 525-line frame, and the strobe marks the line at which the exposure begins. In the long range the exposure lasts between 2 and 16 whole frames. The strobe then fires once at the start of each multi-frame cycle, and only the readout that closes the last frame of the cycle is flagged as valid.

The code is sampled only in the cycle that carries the frame-start strobe, and it governs the whole frame from that cycle on. Code changes between boundaries are therefore ignored. In long mode the block also raises a level that asks the black-level clamp to stand down, because the clamp cannot track an image that is read out only every Nth frame. The block carries no data stream. Every pin is a plain level or strobe, so there is no handshake and no back-pressure. Lines are numbered 1 to 525, and the frame-start strobe is one cycle wide, in the first cycle of line 1.

Top module: `shtr_ctrl`

## Requirements
- R1: Code 0x000 turns the shutter off. The exposure is the full frame, `str_o` never rises, and `clamp_off_o` stays low.
- R2: Codes 0x001 to 0x20B select line mode with an exposure of code+1 lines. `str_o` is high during line 524−code.
- R3: At the ends of the line range, code 0x001 places `str_o` on line 523 and code 0x20B places it on line 1.
- R4: In line mode `str_o` is high for exactly the cycles of one line, once per frame.
- R5: Codes 0x301 to 0x30F select long mode, with an exposure of (code bits [3:0])+1 frames. `clamp_off_o` is high for every cycle of a frame that runs in long mode.
- R6: In long mode a frame counter steps 1..N. `str_o` is high only during line 1 of frame 1 of each cycle.
- R7: `frame_valid_o` is a one-cycle pulse that coincides with `frame_start`. After an off frame or a line-mode frame it always pulses. After a long-mode frame it pulses only if that frame was frame N.
- R8: All other codes act as shutter off. These are 0x20C–0x2FF, 0x300, 0x310–0x3FF, and every code with bits [7:4] non-zero in the 0x3xx space.
- R9: A code is taken up only in the `frame_start` cycle and applies from that cycle. A change made within a frame has no effect until the next boundary.
- R10: A long-mode cycle restarts at frame 1 whenever the code at a boundary differs from the code held for the previous frame.
- R11: After reset the block is in the off state. `str_o` and `clamp_off_o` are low until a boundary applies a code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shutter_code | input | 10 | Requested shutter code |
| line_idx | input | 10 | Current line number, 1..525 |
| frame_start | input | 1 | One-cycle strobe in the first cycle of line 1 |
| str_o | output | 1 | Storage-start strobe, one line wide |
| frame_valid_o | output | 1 | Readout of the frame that just closed is usable |
| clamp_off_o | output | 1 | Request to disable the automatic black-level clamp |

## Verification
A table of codes drives one frame per entry. It covers the off code, both ends of the line range, mid-range line codes, the first and last long codes, and the out-of-range neighbours on each side of every range. Each entry yields the strobe line, the strobe length, the clamp level and the boundary valid flag, which together tell line, long and rejected codes apart. A run of long-mode frames at a fixed code shows the 1..N cadence of both the strobe and the valid flag. A code change in the middle of a long-mode cycle shows that the counter restarts. Codes altered in the middle of a frame, and the state just after reset, show that nothing outside a boundary takes effect.

// File: rtl/shtr_pkg.sv
package shtr_pkg;
  typedef enum logic [1:0] {
    SH_OFF  = 2'd0,
    SH_LINE = 2'd1,
    SH_LONG = 2'd2
  } sh_mode_e;
endpackage

// File: rtl/shtr_code_decode.sv
module shtr_code_decode
  import shtr_pkg::*;
#(
  parameter int CODE_W          = 10,
  parameter int LINE_W          = 10,
  parameter int LINES_PER_FRAME = 525,
  parameter int FRM_W           = 4
) (
  input  logic [CODE_W-1:0] code,
  output sh_mode_e          mode,
  output logic [LINE_W-1:0] target_line,
  output logic [FRM_W:0]    frames
);
  localparam int FW = FRM_W + 1;
  localparam logic [CODE_W-1:0] MAX_LINE_CODE = CODE_W'(LINES_PER_FRAME - 2);

  logic is_line, is_long;

  // line mode: any non-zero code up to frame length minus two
  assign is_line = (code != '0) && (code <= MAX_LINE_CODE);
  // long mode: top two bits set, middle bits clear, nibble non-zero
  assign is_long = (code[CODE_W-1 -: 2] == 2'b11) &&
                   (code[CODE_W-3:FRM_W] == '0) &&
                   (code[FRM_W-1:0] != '0);

  always_comb begin
    mode        = SH_OFF;
    target_line = '0;
    frames      = FW'(1);
    if (is_line) begin
      mode        = SH_LINE;
      target_line = LINE_W'(LINES_PER_FRAME - 1 - int'(code));
    end else if (is_long) begin
      mode   = SH_LONG;
      frames = FW'(code[FRM_W-1:0]) + FW'(1);
    end
  end
endmodule

// File: rtl/shtr_frame_seq.sv
module shtr_frame_seq
  import shtr_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int LINE_W = 10,
  parameter int FRM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [CODE_W-1:0] code_in,
  input  sh_mode_e          dec_mode,
  input  logic [LINE_W-1:0] dec_target,
  input  logic [FRM_W:0]    dec_frames,
  output sh_mode_e          eff_mode,
  output logic [LINE_W-1:0] eff_target,
  output logic [FRM_W:0]    eff_frames,
  output logic [FRM_W:0]    eff_fcnt,
  output sh_mode_e          held_mode,
  output logic              frame_valid
);
  localparam int FW = FRM_W + 1;

  sh_mode_e          mode_q;
  logic [LINE_W-1:0] target_q;
  logic [FW-1:0]     frames_q;
  logic [FW-1:0]     fcnt_q;
  logic [CODE_W-1:0] code_q;
  logic [FW-1:0]     fcnt_nx;
  logic              code_chg;

  assign code_chg = (code_in != code_q);

  always_comb begin
    if (code_chg || dec_mode != SH_LONG) fcnt_nx = FW'(1);
    else if (fcnt_q >= frames_q)         fcnt_nx = FW'(1);
    else                                 fcnt_nx = fcnt_q + FW'(1);
  end

  // a boundary applies the freshly decoded code within its own cycle
  assign eff_mode   = frame_start ? dec_mode   : mode_q;
  assign eff_target = frame_start ? dec_target : target_q;
  assign eff_frames = frame_start ? dec_frames : frames_q;
  assign eff_fcnt   = frame_start ? fcnt_nx    : fcnt_q;
  assign held_mode  = mode_q;

  // the frame now closing was usable unless it sat inside a long cycle
  assign frame_valid = frame_start && ((mode_q != SH_LONG) || (fcnt_q == frames_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SH_OFF;
      target_q <= '0;
      frames_q <= FW'(1);
      fcnt_q   <= FW'(1);
      code_q   <= '0;
    end else if (frame_start) begin
      mode_q   <= dec_mode;
      target_q <= dec_target;
      frames_q <= dec_frames;
      fcnt_q   <= fcnt_nx;
      code_q   <= code_in;
    end
  end
endmodule

// File: rtl/shtr_str_gen.sv
module shtr_str_gen
  import shtr_pkg::*;
#(
  parameter int LINE_W        = 10,
  parameter int FRM_W         = 4,
  parameter int LONG_STR_LINE = 1
) (
  input  sh_mode_e          mode,
  input  logic [LINE_W-1:0] target,
  input  logic [FRM_W:0]    fcnt,
  input  logic [LINE_W-1:0] line_idx,
  output logic              str
);
  localparam logic [LINE_W-1:0] LONG_LINE = LINE_W'(LONG_STR_LINE);
  localparam logic [FRM_W:0]    FIRST_FRM = (FRM_W + 1)'(1);

  logic line_hit, long_hit;

  assign line_hit = (mode == SH_LINE) && (line_idx == target);
  assign long_hit = (mode == SH_LONG) && (fcnt == FIRST_FRM) && (line_idx == LONG_LINE);
  assign str      = line_hit || long_hit;
endmodule

// File: rtl/shtr_ctrl.sv
module shtr_ctrl
  import shtr_pkg::*;
#(
  parameter int CODE_W          = 10,
  parameter int LINE_W          = 10,
  parameter int LINES_PER_FRAME = 525,
  parameter int FRM_W           = 4,
  parameter int LONG_STR_LINE   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] shutter_code,
  input  logic [LINE_W-1:0] line_idx,
  input  logic              frame_start,
  output logic              str_o,
  output logic              frame_valid_o,
  output logic              clamp_off_o
);
  sh_mode_e          dec_mode, eff_mode, held_mode;
  logic [LINE_W-1:0] dec_target, eff_target;
  logic [FRM_W:0]    dec_frames, eff_frames, eff_fcnt;

  shtr_code_decode #(
    .CODE_W(CODE_W), .LINE_W(LINE_W),
    .LINES_PER_FRAME(LINES_PER_FRAME), .FRM_W(FRM_W)
  ) u_dec (
    .code(shutter_code), .mode(dec_mode),
    .target_line(dec_target), .frames(dec_frames)
  );

  shtr_frame_seq #(
    .CODE_W(CODE_W), .LINE_W(LINE_W), .FRM_W(FRM_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .code_in(shutter_code), .dec_mode(dec_mode),
    .dec_target(dec_target), .dec_frames(dec_frames),
    .eff_mode(eff_mode), .eff_target(eff_target),
    .eff_frames(eff_frames), .eff_fcnt(eff_fcnt),
    .held_mode(held_mode), .frame_valid(frame_valid_o)
  );

  shtr_str_gen #(
    .LINE_W(LINE_W), .FRM_W(FRM_W), .LONG_STR_LINE(LONG_STR_LINE)
  ) u_str (
    .mode(eff_mode), .target(eff_target), .fcnt(eff_fcnt),
    .line_idx(line_idx), .str(str_o)
  );

  assign clamp_off_o = (eff_mode == SH_LONG);
endmodule

// File: rtl/shtr_ctrl_chk.sv
module shtr_ctrl_chk
  import shtr_pkg::*;
#(
  parameter int LINE_W        = 10,
  parameter int FRM_W         = 4,
  parameter int LONG_STR_LINE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [LINE_W-1:0] line_idx,
  input logic              str_o,
  input logic              frame_valid_o,
  input logic              clamp_off_o,
  input sh_mode_e          eff_mode,
  input sh_mode_e          held_mode,
  input logic [FRM_W:0]    eff_fcnt,
  input logic [FRM_W:0]    eff_frames
);
  localparam logic [LINE_W-1:0] LONG_LINE = LINE_W'(LONG_STR_LINE);
  localparam logic [FRM_W:0]    ONE_FRM   = (FRM_W + 1)'(1);

  AST_OFF_NO_STR: assert property (@(posedge clk) disable iff (!rst_n)
    str_o |-> (eff_mode != SH_OFF)); // R1

  AST_STR_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    str_o |=> (!str_o || $stable(line_idx))); // R4

  AST_CLAMP_LONG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_off_o |-> (eff_frames > ONE_FRM)); // R5

  AST_FCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mode == SH_LONG) |-> ((eff_fcnt >= ONE_FRM) && (eff_fcnt <= eff_frames))); // R6

  AST_LONG_STR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (str_o && clamp_off_o) |-> (line_idx == LONG_LINE)); // R6

  AST_VALID_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> frame_start); // R7

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(held_mode)); // R9
endmodule

bind shtr_ctrl shtr_ctrl_chk #(
  .LINE_W(LINE_W), .FRM_W(FRM_W), .LONG_STR_LINE(LONG_STR_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_idx(line_idx),
  .str_o(str_o), .frame_valid_o(frame_valid_o), .clamp_off_o(clamp_off_o),
  .eff_mode(eff_mode), .held_mode(held_mode),
  .eff_fcnt(eff_fcnt), .eff_frames(eff_frames)
);

// File: tb/shtr_ctrl_tb.sv
module shtr_ctrl_tb;
  localparam int NLINES = 525;
  localparam int CPL    = 2;           // clocks per line
  localparam int FRAME_CYC = NLINES * CPL;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] shutter_code = '0;
  logic [9:0] line_idx = 10'd1;
  logic       frame_start = 1'b0;
  logic       str_o, frame_valid_o, clamp_off_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // results of the most recent frame
  int f_valid0, f_str_cyc, f_str_line, f_clamp_cyc, f_stray_valid;

  always #10 clk = ~clk;

  shtr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .shutter_code(shutter_code),
    .line_idx(line_idx), .frame_start(frame_start),
    .str_o(str_o), .frame_valid_o(frame_valid_o), .clamp_off_o(clamp_off_o)
  );

  typedef struct packed {
    logic [9:0] code;
    logic [9:0] line;   // expected strobe line, 0 for none
    logic       clamp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{10'h000, 10'd0,   1'b0},
    '{10'h001, 10'd523, 1'b0},
    '{10'h002, 10'd522, 1'b0},
    '{10'h100, 10'd268, 1'b0},
    '{10'h20B, 10'd1,   1'b0},
    '{10'h20C, 10'd0,   1'b0},
    '{10'h2FF, 10'd0,   1'b0},
    '{10'h300, 10'd0,   1'b0},
    '{10'h301, 10'd1,   1'b1},
    '{10'h30F, 10'd1,   1'b1},
    '{10'h310, 10'd0,   1'b0},
    '{10'h3FF, 10'd0,   1'b0},
    '{10'h1F0, 10'd28,  1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one full frame; code applied at the boundary, optional change at mid_line
  task automatic run_frame(input logic [9:0] code, input logic [9:0] mid_code, input int mid_line);
    f_valid0 = 0; f_str_cyc = 0; f_str_line = 0; f_clamp_cyc = 0; f_stray_valid = 0;
    for (int ln = 1; ln <= NLINES; ln++) begin
      for (int c = 0; c < CPL; c++) begin
        @(posedge clk); #2;
        line_idx    = 10'(ln);
        frame_start = (ln == 1 && c == 0);
        if (ln == 1 && c == 0) shutter_code = code;
        if (mid_line != 0 && ln == mid_line && c == 0) shutter_code = mid_code;
        @(negedge clk);
        if (frame_start) f_valid0 = int'(frame_valid_o);
        else if (frame_valid_o) f_stray_valid++;
        if (str_o) begin
          if (f_str_cyc == 0) f_str_line = ln;
          f_str_cyc++;
        end
        if (clamp_off_o) f_clamp_cyc++;
      end
    end
  endtask

  initial begin
    #(150000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    string rq;
    int prev_long;
    int long_v[7];
    int stray_total;
    stray_total = 0;
    // R11: reset state, code pending but no boundary yet
    shutter_code = 10'h001; line_idx = 10'd523;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", "str in reset", int'(str_o), 0);
    chk("R11", "clamp in reset", int'(clamp_off_o), 0);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R11", "str before boundary", int'(str_o), 0);
    chk("R9", "valid without boundary", int'(frame_valid_o), 0);

    // vector table walk, one frame per entry
    prev_long = 0;
    foreach (VECS[i]) begin
      run_frame(VECS[i].code, 10'h0, 0);
      stray_total += f_stray_valid;
      if (VECS[i].clamp) rq = "R5";
      else if (VECS[i].line != 0) rq = (VECS[i].line == 1 || VECS[i].line == 523) ? "R3" : "R2";
      else rq = (VECS[i].code == 0) ? "R1" : "R8";
      chk(rq, $sformatf("str line code %03h", VECS[i].code), f_str_line, int'(VECS[i].line));
      chk("R4", $sformatf("str cycles code %03h", VECS[i].code), f_str_cyc, (VECS[i].line != 0) ? CPL : 0);
      chk(rq, $sformatf("clamp cycles code %03h", VECS[i].code), f_clamp_cyc, VECS[i].clamp ? FRAME_CYC : 0);
      chk("R7", $sformatf("valid at start code %03h", VECS[i].code), f_valid0, prev_long ? 0 : 1);
      prev_long = int'(VECS[i].clamp);
    end

    // R6 / R7: three-frame long cycle repeated
    long_v = '{1, 0, 0, 1, 0, 0, 1};
    for (int k = 0; k < 7; k++) begin
      run_frame(10'h302, 10'h0, 0);
      stray_total += f_stray_valid;
      chk("R6", $sformatf("long3 frame %0d str line", k), f_str_line, (k % 3 == 0) ? 1 : 0);
      chk("R7", $sformatf("long3 frame %0d valid", k), f_valid0, long_v[k]);
      chk("R5", $sformatf("long3 frame %0d clamp", k), f_clamp_cyc, FRAME_CYC);
    end

    // R10: change code inside a cycle restarts counter
    run_frame(10'h303, 10'h0, 0);
    chk("R10", "restart str line", f_str_line, 1);
    chk("R7", "valid after broken cycle", f_valid0, 0);
    for (int k = 1; k < 4; k++) begin
      run_frame(10'h303, 10'h0, 0);
      chk("R6", $sformatf("long4 frame %0d no str", k), f_str_cyc, 0);
      chk("R7", $sformatf("long4 frame %0d valid", k), f_valid0, 0);
    end
    run_frame(10'h000, 10'h0, 0);
    chk("R7", "valid after frame N", f_valid0, 1);
    chk("R1", "off after long clamp", f_clamp_cyc, 0);

    // R9: mid-frame change ignored until next boundary
    run_frame(10'h100, 10'h005, 100);
    chk("R9", "mid change str line", f_str_line, 268);
    chk("R9", "mid change str cycles", f_str_cyc, CPL);
    run_frame(10'h005, 10'h0, 0);
    chk("R2", "next frame str line", f_str_line, 519);
    run_frame(10'h000, 10'h301, 2);
    chk("R9", "mid change to long clamp", f_clamp_cyc, 0);
    chk("R9", "mid change to long str", f_str_cyc, 0);
    stray_total += f_stray_valid;
    chk("R7", "valid away from boundary", stray_total, 0);

    // R11: reset in the middle of long mode
    run_frame(10'h301, 10'h0, 0);
    @(posedge clk); #2;
    frame_start = 1'b0; line_idx = 10'd1;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "clamp after reset", int'(clamp_off_o), 0);
    chk("R11", "str after reset", int'(str_o), 0);
    summary();
  end
endmodule